// File: doc/BRIEF.md
# Backpressure-Bounded Streaming Write Master

This block moves words from an upstream first-word-fall-through buffer onto a parallel streaming bus that feeds a sink. Each cycle in which it drives the bus carries exactly one bus-width word. The bus width is a parameter (8, 16 or 32 bits), and the block is meant to run at about 100 MHz. The sink drives an active-high `snk_ready`. The upstream buffer shows its head word on `up_data`, raises `up_empty` when it has nothing, and advances when the block raises `up_pop`.

The block has three states. `ST_IDLE` drives nothing. `ST_STREAM` drives one word per cycle while `snk_ready` is high. `ST_OVERRUN` covers the sink's reaction latency after backpressure appears.

The transitions are named as follows:
- **T_GO** (`ST_IDLE` to `ST_STREAM`): taken when ready is high.
- **T_BACKOFF** (`ST_STREAM` to `ST_OVERRUN`): taken when ready is low. It loads the overrun counter with zero.
- **T_EXHAUST** (`ST_OVERRUN` to `ST_IDLE`): taken once the counter has seen `OVR_LIMIT` driven words.
- **T_HOLD**: the self-loop of each state.

While in `ST_OVERRUN`, the block keeps driving words until the counter has counted `OVR_LIMIT` of them and ignores `snk_ready`. A sink that keeps room for `OVR_LIMIT` words past its ready drop therefore never loses data.

Top module: `bp_write_master`

## Requirements
- R1: Synchronous active-high `rst` puts the machine in `ST_IDLE` with the counter at zero. In the first cycle after reset, `snk_valid` and `up_pop` are low even if `snk_ready` is high.
- R2: In `ST_STREAM` with `snk_ready` high and `up_empty` low, one word is driven per cycle: `snk_valid`=1, `up_pop`=1, `snk_data`=`up_data`. Words reach the sink in buffer order with none lost or repeated. `snk_data` is zero whenever `snk_valid` is low.
- R3: In `ST_STREAM` with `snk_ready` low, no word is driven in that cycle, and the next state is `ST_OVERRUN` with the counter at zero (T_BACKOFF).
- R4: In `ST_OVERRUN`, a word is driven in each cycle the buffer is non-empty and fewer than `OVR_LIMIT` words have been counted. The cycle that drives the `OVR_LIMIT`-th word is followed by `ST_IDLE` (T_EXHAUST).
- R5: Between a T_BACKOFF and the next entry to `ST_STREAM`, at most `OVR_LIMIT` words are driven. `OVR_LIMIT` defaults to 6 and may be set from 0 to 6.
- R6: `ST_IDLE` drives no word. It stays idle while `snk_ready` is low and moves to `ST_STREAM` in the cycle after `snk_ready` is seen high (T_GO).
- R7: `snk_ready` rising again during `ST_OVERRUN` neither ends nor extends the window. Streaming resumes only via `ST_IDLE`.
- R8: While `up_empty` is high, `snk_valid` and `up_pop` are low and the counter does not advance. State changes then come only from `snk_ready` (T_GO, T_BACKOFF).
- R9: With `OVR_LIMIT`=0, `ST_OVERRUN` lasts one cycle, drives no word, and then goes to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_empty | input | 1 | Upstream buffer has no word |
| up_data | input | DATA_W | Head word of the upstream buffer |
| up_pop | output | 1 | Advance the upstream buffer (word taken) |
| snk_ready | input | 1 | Sink can accept words (active high) |
| snk_valid | output | 1 | A word is on `snk_data` this cycle |
| snk_data | output | DATA_W | Word toward the sink |

## Verification
The hardest case to reach from the ports is a ready drop where the overrun window is interrupted. This happens when the buffer runs dry partway through the window, or when ready comes back before the window is used up. Either way the count of driven words, not the count of cycles, has to end the window. The stimulus has separate phases to reach these cases:
- short single-cycle ready dips;
- long ready-low stretches;
- a pseudo-random empty pattern overlaid on both kinds of dip.

A second instance with a zero-length window runs on the same stimulus.

// File: rtl/bp_write_master_pkg.sv
package bp_write_master_pkg;

    // Machine states of the write master
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STREAM  = 2'd1,
        ST_OVERRUN = 2'd2
    } bpwm_state_e;

    // Largest legal overrun window
    localparam int unsigned OVR_MAX = 6;

endpackage

// File: rtl/bpwm_ovr_counter.sv
module bpwm_ovr_counter #(
    parameter int unsigned OVR_LIMIT = 6,
    parameter int unsigned CNT_W     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic inc,
    output logic at_limit,
    output logic one_left
);

    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(OVR_LIMIT);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            count_q <= '0;
        end else if (inc && (count_q != LIM_V)) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign at_limit = (count_q == LIM_V);

    generate
        if (OVR_LIMIT > 0) begin : g_window
            localparam logic [CNT_W-1:0] LAST_V = CNT_W'(OVR_LIMIT - 1);
            assign one_left = (count_q == LAST_V);
        end else begin : g_nowindow
            assign one_left = 1'b0;
        end
    endgenerate

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= LIM_V);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load) |=> $stable(count_q));

endmodule

// File: rtl/bpwm_fsm.sv
module bpwm_fsm
    import bp_write_master_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ready,
    input  logic        word_sent,
    input  logic        at_limit,
    input  logic        one_left,
    output bpwm_state_e state,
    output logic        ovr_load,
    output logic        ovr_inc
);

    bpwm_state_e state_q;
    bpwm_state_e state_d;
    logic        exhaust;

    assign exhaust = at_limit || (word_sent && one_left);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (ready)   state_d = ST_STREAM;   // T_GO
            ST_STREAM:  if (!ready)  state_d = ST_OVERRUN;  // T_BACKOFF
            ST_OVERRUN: if (exhaust) state_d = ST_IDLE;     // T_EXHAUST
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ovr_load = 1'b0;
        ovr_inc  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_STREAM:  ovr_load = !ready;
            ST_OVERRUN: ovr_inc  = word_sent;
            default:    ;
        endcase
    end

    assign state = state_q;

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !ready) |=> (state_q == ST_IDLE));

    // R3
    stream_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && !ready) |=> (state_q == ST_OVERRUN));

    // R7
    ovr_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVERRUN && !at_limit && !(word_sent && one_left))
            |=> (state_q == ST_OVERRUN));

    // R7
    no_ovr_to_stream_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OVERRUN) |=> (state_q != ST_STREAM));

endmodule

// File: rtl/bpwm_drive.sv
module bpwm_drive
    import bp_write_master_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bpwm_state_e       state,
    input  logic              ready,
    input  logic              at_limit,
    input  logic              up_empty,
    input  logic [DATA_W-1:0] up_data,
    output logic              word_sent,
    output logic              up_pop,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data
);

    logic allowed;

    always_comb begin
        allowed = 1'b0;
        unique case (state)
            ST_IDLE:    allowed = 1'b0;
            ST_STREAM:  allowed = ready;
            ST_OVERRUN: allowed = !at_limit;
            default:    allowed = 1'b0;
        endcase
    end

    assign word_sent = allowed && !up_empty;
    assign up_pop    = word_sent;
    assign snk_valid = word_sent;
    assign snk_data  = word_sent ? up_data : '0;

    // R8
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        up_empty |-> !snk_valid);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !snk_valid);

    // R2
    data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !snk_valid |-> (snk_data == '0));

endmodule

// File: rtl/bp_write_master.sv
module bp_write_master
    import bp_write_master_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned OVR_LIMIT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_empty,
    input  logic [DATA_W-1:0] up_data,
    output logic              up_pop,
    input  logic              snk_ready,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data
);

    localparam int unsigned CNT_W = $clog2(OVR_MAX + 1);

    bpwm_state_e state;
    logic        ovr_load;
    logic        ovr_inc;
    logic        at_limit;
    logic        one_left;
    logic        word_sent;

    bpwm_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ready     (snk_ready),
        .word_sent (word_sent),
        .at_limit  (at_limit),
        .one_left  (one_left),
        .state     (state),
        .ovr_load  (ovr_load),
        .ovr_inc   (ovr_inc)
    );

    bpwm_ovr_counter #(
        .OVR_LIMIT (OVR_LIMIT),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ovr_load),
        .inc      (ovr_inc),
        .at_limit (at_limit),
        .one_left (one_left)
    );

    bpwm_drive #(
        .DATA_W (DATA_W)
    ) u_drive (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .ready     (snk_ready),
        .at_limit  (at_limit),
        .up_empty  (up_empty),
        .up_data   (up_data),
        .word_sent (word_sent),
        .up_pop    (up_pop),
        .snk_valid (snk_valid),
        .snk_data  (snk_data)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !snk_valid);

    // R2
    pop_match_chk: assert property (@(posedge clk) disable iff (rst)
        up_pop == snk_valid);

endmodule

// File: tb/bp_write_master_tb_top.sv
module bp_write_master_tb_top;

    localparam int DW     = 16;
    localparam int NCYC   = 1500;
    localparam int WD_CYC = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rdy = 1'b0;
    logic emp = 1'b1;
    logic [DW-1:0] updat [2];
    logic [1:0]    pop;
    logic [1:0]    vld;
    logic [DW-1:0] sdat [2];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bp_write_master #(.DATA_W(DW), .OVR_LIMIT(6)) dut_i (
        .clk(clk), .rst(rst), .up_empty(emp), .up_data(updat[0]), .up_pop(pop[0]),
        .snk_ready(rdy), .snk_valid(vld[0]), .snk_data(sdat[0]));

    bp_write_master #(.DATA_W(DW), .OVR_LIMIT(0)) dut_z_i (
        .clk(clk), .rst(rst), .up_empty(emp), .up_data(updat[1]), .up_pop(pop[1]),
        .snk_ready(rdy), .snk_valid(vld[1]), .snk_data(sdat[1]));

    // Reference model state: 0 idle, 1 stream, 2 overrun
    int m_st [2];
    int m_cnt [2];
    int m_lim [2];
    int src_idx [2];
    int since_fall [2];
    bit armed [2];
    bit re_hi [2];
    bit after_rst;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int inst, input int idx);
        return DW'(((inst + 1) << 12) ^ (idx * 7 + 3));
    endfunction

    initial begin : watchdog
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lfsr;
        m_lim[0] = 6;
        m_lim[1] = 0;
        lfsr = 16'hACE1;
        for (int i = 0; i < 2; i++) begin
            m_st[i] = 0; m_cnt[i] = 0; src_idx[i] = 0;
            since_fall[i] = 0; armed[i] = 0; re_hi[i] = 0;
            updat[i] = word_of(i, 0);
        end
        rdy = 1'b1;
        emp = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        after_rst = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rst = (c == 0) || (c == 1000) || (c == 1001);
            if (c < 200) begin
                rdy = 1'b1; emp = 1'b0;
            end else if (c < 600) begin
                rdy = lfsr[0] | lfsr[3];
                emp = lfsr[5] & lfsr[7];
            end else if (c < 900) begin
                rdy = (c % 10) != 0;
                emp = (c >= 750) ? (lfsr[2] & lfsr[9]) : 1'b0;
            end else if (c < 1300) begin
                rdy = (c % 25) >= 20;
                emp = lfsr[4] & lfsr[1] & lfsr[11];
            end else if (c < 1400) begin
                rdy = 1'b1; emp = 1'b1;
            end else begin
                rdy = (c % 3) != 0;
                emp = (c % 7) == 0;
            end
            for (int i = 0; i < 2; i++) updat[i] = word_of(i, src_idx[i]);
            #1;
            for (int i = 0; i < 2; i++) begin
                bit ev;
                string tag;
                ev = !emp && ((m_st[i] == 1 && rdy) || (m_st[i] == 2 && m_cnt[i] < m_lim[i]));
                if (after_rst) tag = "R1";
                else if (i == 1 && m_st[i] == 2) tag = "R9";
                else if (emp) tag = "R8";
                else if (m_st[i] == 0) tag = "R6";
                else if (m_st[i] == 1) tag = rdy ? "R2" : "R3";
                else tag = re_hi[i] ? "R7" : "R4";
                chk(vld[i] == ev, tag, int'(vld[i]), int'(ev));
                chk(pop[i] == ev, tag, int'(pop[i]), int'(ev));
                if (ev) begin
                    chk(sdat[i] == word_of(i, src_idx[i]), "R2", int'(sdat[i]),
                        int'(word_of(i, src_idx[i])));
                end else begin
                    chk(sdat[i] == '0, "R2", int'(sdat[i]), 0);
                end
                if (armed[i] && vld[i]) since_fall[i]++;
                if (armed[i]) chk(since_fall[i] <= m_lim[i], "R5", since_fall[i], m_lim[i]);
            end
            @(posedge clk);
            after_rst = rst;
            for (int i = 0; i < 2; i++) begin
                bit ev;
                ev = !emp && ((m_st[i] == 1 && rdy) || (m_st[i] == 2 && m_cnt[i] < m_lim[i]));
                if (ev) src_idx[i]++;
                if (rst) begin
                    m_st[i] = 0; m_cnt[i] = 0; armed[i] = 0; re_hi[i] = 0; since_fall[i] = 0;
                end else begin
                    case (m_st[i])
                        0: if (rdy) begin m_st[i] = 1; armed[i] = 0; end
                        1: if (!rdy) begin
                               m_st[i] = 2; m_cnt[i] = 0; armed[i] = 1;
                               since_fall[i] = 0; re_hi[i] = 0;
                           end
                        default: begin
                            if (ev) m_cnt[i]++;
                            if (rdy) re_hi[i] = 1;
                            if (m_cnt[i] >= m_lim[i]) m_st[i] = 0;
                        end
                    endcase
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule